// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block merges five event sources into a single active-high interrupt request. Two sources watch a 16-bit digital input word, one for each byte, and fire when any bit of that byte differs from its previous sample. The other three sources follow the outputs of three counter channels. Each counter source fires on one edge of its output, and a per-channel polarity input chooses which edge.

Every source feeds a sticky pending flag that can only be set while the source is enabled. Software uses a small byte-wide register bus with two locations: a read/write enable mask and a read-only status byte showing the pending flags. To acknowledge a source, software writes its enable bit to 0 and then back to 1. The inputs are asynchronous to the block clock, so both the data word and the counter outputs pass through two-flop synchronizers before edge detection.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, the status register reads 0x00 and `irq` is 0.
- R2: A write with `bus_addr`=0 stores `bus_wdata[4:0]` as the enable mask, and the new mask appears on `bus_rdata` from the following cycle. Bits 7..5 always read 0. `bus_rdata` follows `bus_addr` in the same cycle.
- R3: With `bus_addr`=1, `bus_rdata[4:0]` shows the pending flags and bits 7..5 read 0. Writes to address 1 change nothing.
- R4: Bit 0 is the low-byte change source. A change of any bit of `din[7:0]` that is stable before rising edge n sets pending bit 0 at edge n+2, if the source is enabled.
- R5: Bit 1 is the high-byte change source. It behaves as R4 but for `din[15:8]`.
- R6: Bits 2, 3 and 4 belong to counters 0, 1 and 2. With `ctr_pol[k]`=1, a rising edge of `ctr_out[k]` sets the flag. With `ctr_pol[k]`=0, a falling edge sets it. The flag sets at the same latency as R4. A steady level never sets the flag again.
- R7: A source event that occurs while its enable bit is 0 is lost. It does not show in the status later, after the bit is enabled.
- R8: A pending flag stays set while its enable bit stays 1, even after the source goes quiet. The flag is cleared in the cycle after its enable bit is 0. Writing the bit back to 1 leaves the flag clear until a new event arrives.
- R9: `irq` is 1 exactly when some source has both its pending flag and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 16 | Asynchronous digital input word |
| ctr_out | input | 3 | Counter channel outputs, asynchronous |
| ctr_pol | input | 3 | Per-counter edge select: 1 = rising, 0 = falling |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 = enable, 1 = status |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the selected address |
| irq | output | 1 | Interrupt request, active high |

## Verification
Single-bit flips in each byte show whether the two change detectors are mapped to the correct byte lanes, and whether they respond to differences rather than to levels. Counter outputs are driven with both polarity settings, and rises, falls and long steady levels are applied. These patterns separate true edge detection from level detection and also confirm that the polarity choice is honoured. Events are also applied while the source is disabled, and the disable-then-re-enable acknowledge sequence is exercised, so that a lost event can be told apart from a stale flag. A long stretch of random input toggles, polarity changes and mask writes is then compared against a behavioural reference model on every cycle.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cos_rst_sync.sv
module cos_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cos_sync_stage.sv
// Two-flop synchronizer followed by one history register.
module cos_sync_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign prev = prev_q;
endmodule

// File: rtl/cos_group_detect.sv
// One change flag per group of GROUP_W bits.
module cos_group_detect #(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 8,
  localparam int NGRP   = DATA_W / GROUP_W
) (
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] prev,
  output logic [NGRP-1:0]   evt
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign evt[g] = |(cur[g*GROUP_W +: GROUP_W] ^ prev[g*GROUP_W +: GROUP_W]);
  end
endmodule

// File: rtl/cos_edge_detect.sv
// Per-channel edge detector with selectable edge.
module cos_edge_detect #(
  parameter int N = 3
) (
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prev,
  input  logic [N-1:0] pol,
  output logic [N-1:0] evt
);
  for (genvar k = 0; k < N; k++) begin : g_ch
    logic rise, fall;
    assign rise   = cur[k] & ~prev[k];
    assign fall   = ~cur[k] & prev[k];
    assign evt[k] = pol[k] ? rise : fall;
  end
endmodule

// File: rtl/cos_irq_regs.sv
module cos_irq_regs
  import cos_irq_pkg::*;
#(
  parameter int NSRC = 5
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             bus_we,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [NSRC-1:0]  src_evt,
  output logic [NSRC-1:0]  en_q,
  output logic [NSRC-1:0]  pend_q,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int PAD_W = REG_W - NSRC;

  logic            en_load;
  logic [NSRC-1:0] en_d, pend_d;
  logic            wdata_unused;

  assign wdata_unused = ^bus_wdata[REG_W-1:NSRC];

  always_comb begin
    en_load = bus_we && (bus_addr == SEL_ENABLE);
    en_d    = en_load ? bus_wdata[NSRC-1:0] : en_q;
    pend_d  = en_q & (pend_q | src_evt);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    if (bus_addr == SEL_STATUS) bus_rdata = {{PAD_W{1'b0}}, pend_q};
    else                        bus_rdata = {{PAD_W{1'b0}}, en_q};
  end

  assign irq = |(pend_q & en_q);
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_irq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 8,
  parameter int NUM_CTR = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  din,
  input  logic [NUM_CTR-1:0] ctr_out,
  input  logic [NUM_CTR-1:0] ctr_pol,
  input  logic               bus_we,
  input  logic               bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic               irq
);
  localparam int NUM_GRP = DATA_W / GROUP_W;
  localparam int NUM_SRC = NUM_GRP + NUM_CTR;

  logic                rst_int_n;
  logic [DATA_W-1:0]   d_cur, d_prev;
  logic [NUM_CTR-1:0]  c_cur, c_prev;
  logic [NUM_GRP-1:0]  grp_evt;
  logic [NUM_CTR-1:0]  ctr_evt;
  logic [NUM_SRC-1:0]  src_evt, en_q, pend_q;

  cos_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  cos_sync_stage #(.W(DATA_W)) u_dsync (
    .clk(clk), .rst_ni(rst_int_n), .async_in(din), .cur(d_cur), .prev(d_prev));

  cos_sync_stage #(.W(NUM_CTR)) u_csync (
    .clk(clk), .rst_ni(rst_int_n), .async_in(ctr_out), .cur(c_cur), .prev(c_prev));

  cos_group_detect #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) u_grp (
    .cur(d_cur), .prev(d_prev), .evt(grp_evt));

  cos_edge_detect #(.N(NUM_CTR)) u_edge (
    .cur(c_cur), .prev(c_prev), .pol(ctr_pol), .evt(ctr_evt));

  assign src_evt = {ctr_evt, grp_evt};

  cos_irq_regs #(.NSRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_ni(rst_int_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .src_evt(src_evt), .en_q(en_q), .pend_q(pend_q),
    .bus_rdata(bus_rdata), .irq(irq));
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk #(
  parameter int NSRC  = 5,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_ni,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  pend_q,
  input logic [NSRC-1:0]  evt,
  input logic             bus_we,
  input logic             bus_addr,
  input logic [REG_W-1:0] bus_wdata,
  input logic [REG_W-1:0] bus_rdata,
  input logic             irq
);
  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_we && !bus_addr) |=> (en_q == $past(bus_wdata[NSRC-1:0])));

  assert_status_pad_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    bus_addr |-> (bus_rdata[REG_W-1:NSRC] == '0));

  assert_event_latched_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (($past(evt) & $past(en_q)) != '0) |-> ((($past(evt) & $past(en_q)) & ~pend_q) == '0));

  assert_no_spurious_set_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q != $past(pend_q)) |-> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (($past(pend_q) & $past(en_q)) != '0) |-> ((($past(pend_q) & $past(en_q)) & ~pend_q) == '0));

  assert_clear_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_q != '1) |=> ((pend_q & ~$past(en_q)) == '0));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> (pend_q != '0));
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.NSRC(NUM_SRC), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst_ni(rst_int_n), .en_q(en_q), .pend_q(pend_q), .evt(src_evt),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq));

// File: tb/cos_irq_ctrl_tb.sv
module cos_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] din;
  logic [2:0]  ctr_out, ctr_pol;
  logic        bus_we, bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit model_run = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cos_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .ctr_out(ctr_out), .ctr_pol(ctr_pol),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Behavioural reference: history queues of sampled inputs.
  logic [15:0] hd[$];
  logic [2:0]  hc[$];
  logic [4:0]  m_en, m_pend, m_evt;

  always @(posedge clk) begin
    if (!model_run) begin
      hd = '{16'h0, 16'h0, 16'h0, 16'h0};
      hc = '{3'h0, 3'h0, 3'h0, 3'h0};
      m_en = '0;
      m_pend = '0;
    end else begin
      hd.push_front(din);
      void'(hd.pop_back());
      hc.push_front(ctr_out);
      void'(hc.pop_back());
      m_evt[0] = (hd[2][7:0] != hd[3][7:0]);
      m_evt[1] = (hd[2][15:8] != hd[3][15:8]);
      for (int k = 0; k < 3; k++)
        m_evt[2+k] = ctr_pol[k] ? (hc[2][k] & !hc[3][k]) : (!hc[2][k] & hc[3][k]);
      m_pend = m_en & (m_pend | m_evt);
      if (bus_we && !bus_addr) m_en = bus_wdata[4:0];
    end
  end

  always @(negedge clk) begin
    if (model_run) begin
      #1;
      check("R9 irq", {7'b0, irq}, {7'b0, |(m_pend & m_en)});
      if (bus_addr) check("R3 status", bus_rdata, {3'b0, m_pend});
      else          check("R2 enable", bus_rdata, {3'b0, m_en});
    end
  end

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #2;
    check(tag, bus_rdata, exp);
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    @(negedge clk);
    #2;
    check(tag, {7'b0, irq}, {7'b0, exp});
  endtask

  task automatic ack(input logic [7:0] clr);
    bus_write(1'b0, 8'h1F & ~clr);
    bus_write(1'b0, 8'h1F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; din = '0; ctr_out = '0; ctr_pol = 3'b101;
    bus_we = 1'b0; bus_addr = 1'b1; bus_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(6);
    // R1 reset state
    expect_reg(1'b0, 8'h00, "R1 enable after reset");
    expect_reg(1'b1, 8'h00, "R1 status after reset");
    expect_irq(1'b0, "R1 irq after reset");
    model_run = 1'b1;

    // R2 mask readback, upper bits drop
    bus_write(1'b0, 8'hFF);
    expect_reg(1'b0, 8'h1F, "R2 enable readback");
    bus_write(1'b0, 8'h00);
    // R7 event while disabled is lost
    din = 16'h0001;
    idle(5);
    bus_write(1'b0, 8'h1F);
    idle(5);
    expect_reg(1'b1, 8'h00, "R7 disabled change lost");
    // R3 write to status ignored
    bus_write(1'b1, 8'hFF);
    expect_reg(1'b1, 8'h00, "R3 status write ignored");
    expect_reg(1'b0, 8'h1F, "R3 enable untouched by status write");
    // R4 low byte
    din = din ^ 16'h0080;
    idle(5);
    expect_reg(1'b1, 8'h01, "R4 low byte change");
    expect_irq(1'b1, "R9 irq with pending");
    // R5 high byte
    din = din ^ 16'h1000;
    idle(5);
    expect_reg(1'b1, 8'h03, "R5 high byte change");
    // R8 sticky then acknowledge
    idle(10);
    expect_reg(1'b1, 8'h03, "R8 flags sticky");
    ack(8'h01);
    idle(2);
    expect_reg(1'b1, 8'h02, "R8 ack clears bit 0 only");
    ack(8'h02);
    idle(2);
    expect_reg(1'b1, 8'h00, "R8 ack clears bit 1");
    expect_irq(1'b0, "R9 irq low with nothing pending");
    // R6 counter edges, pol = 101
    ctr_out = 3'b001;
    idle(5);
    expect_reg(1'b1, 8'h04, "R6 ctr0 rising sets");
    ack(8'h04);
    idle(5);
    expect_reg(1'b1, 8'h00, "R6 steady high no reset");
    ctr_out = 3'b011;
    idle(5);
    expect_reg(1'b1, 8'h00, "R6 ctr1 rising ignored with pol 0");
    ctr_out = 3'b001;
    idle(5);
    expect_reg(1'b1, 8'h08, "R6 ctr1 falling sets");
    ack(8'h08);
    ctr_out = 3'b000;
    idle(5);
    expect_reg(1'b1, 8'h00, "R6 ctr0 falling ignored with pol 1");
    // R7 counter event while disabled
    bus_write(1'b0, 8'h0F);
    ctr_out = 3'b100;
    idle(5);
    bus_write(1'b0, 8'h1F);
    idle(5);
    expect_reg(1'b1, 8'h00, "R7 ctr2 edge while disabled lost");
    // R9 irq drop on disable
    ctr_out = 3'b000;
    idle(5);
    ctr_out = 3'b100;
    idle(5);
    expect_reg(1'b1, 8'h10, "R6 ctr2 rising sets");
    expect_irq(1'b1, "R9 irq from ctr2");
    bus_write(1'b0, 8'h0F);
    expect_irq(1'b0, "R9 irq drops when disabled");
    bus_write(1'b0, 8'h1F);
    idle(2);
    expect_reg(1'b1, 8'h00, "R8 flag gone after re-enable");

    // Random phase, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if ($urandom % 4 == 0) din = din ^ 16'(16'h1 << ($urandom % 16));
      if ($urandom % 6 == 0) ctr_out = ctr_out ^ 3'(3'b1 << ($urandom % 3));
      if (i % 100 == 0) ctr_pol = 3'($urandom);
      bus_we = ($urandom % 8 == 0);
      bus_addr = 1'($urandom);
      bus_wdata = 8'($urandom);
    end
    @(negedge clk);
    bus_we = 1'b0;
    idle(4);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule